// File: doc/BRIEF.md
# Transmit Descriptor Ring Gather Engine

This block drains a ring of transmit descriptors held in system memory and turns them into one ordered byte stream. Software places descriptors in a contiguous array, each one naming a fragment buffer, its length and whether it closes a frame. Software then moves a produce index forward. The engine fetches each descriptor, reads the fragment's words and emits its bytes. It then writes a status word into a parallel status array and steps its consume index. A frame can span any number of consecutive descriptors, and their bytes leave as one unbroken stream.

Three interfaces are used. A plain register write port sets the descriptor array base, the status array base, the ring entry count and the produce index. A word-wide memory port carries one request at a time. A request stays asserted, with address, direction and write data held, until `mem_gnt`. A read returns its word on `mem_rvalid` at least one cycle after the grant. The byte output uses valid/ready. Once `out_valid` is raised, the byte and its `out_last` flag stay fixed and valid stays high until a cycle with `out_ready` high. A byte moves on every cycle where both are high, and the consumer may hold `out_ready` low for any length of time.

Descriptor layout: word 0 holds the fragment's byte address. Word 1 is the control word: bits [10:0] hold the byte count minus one, and bit 30 marks the last fragment of a frame. Descriptor `i` sits at descriptor base + 8·i. Its status word sits at status base + 4·i. The register select values are 0 for the descriptor base, 1 for the status base, 2 for the entry count and 3 for the produce index.

Top module: `txring_dma`

## Requirements
- R1: After reset the consume index reads 0, `mem_req` is low and `out_valid` is low; the entry count resets to 0.
- R2: While the produce and consume indices are equal, the engine issues no memory request and presents no byte.
- R3: For the descriptor at the consume index `i`, the first read is at descriptor base + 8·i (the buffer address) and the second read is at descriptor base + 8·i + 4 (the control word).
- R4: A fragment's bytes leave in ascending address order starting at any byte alignment. The byte at address `a` is bits [8·(a mod 4)+7 : 8·(a mod 4)] of the word at `a` rounded down to a multiple of 4. Exactly size-field + 1 bytes are sent.
- R5: Consecutive descriptors form one stream with no reordering. `out_last` is high only on the final byte of a descriptor whose control bit 30 is set.
- R6: After a fragment's final byte is accepted, one write goes to status base + 4·i with bit 31 = 1, bit 30 = the descriptor's last flag, bits [10:0] = its size field and all other bits 0. No byte is presented while that write is pending.
- R7: The consume index changes only on the cycle after a status write is granted, or on an entry-count write. It steps by one and wraps from count − 1 to 0.
- R8: A produce-index write whose value is not below the entry count is ignored.
- R9: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high with the same `out_data` and `out_last`.
- R10: While `mem_req` is high and `mem_gnt` is low, the next cycle keeps `mem_req` high with the same address, direction and write data.
- R11: A produce-index write landing in the same cycle as a status-write grant takes effect, and the consume index still steps.
- R12: Writing the entry count clears both the produce and the consume index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 desc base, 1 status base, 2 count, 3 produce) |
| reg_wdata | input | AW | Register write value |
| cons_idx | output | IDXW | Consume index |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | DW | Write data (status word) |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| out_valid | output | 1 | Stream byte valid |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of a frame |
| out_ready | input | 1 | Consumer accepts the byte |

## Verification
Two events can land in one cycle: the consume index advancing when a status write is granted, and software moving the produce index. The bench holds back a produce-index write until the cycle its memory model grants a status write, so that both updates hit the same edge. The result is judged by comparing the consume index against the model on every clock. The bench also confirms that the descriptor published in that collision is then fetched, streamed and retired.

// File: rtl/txring_pkg.sv
package txring_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADR_REQ,
    ST_ADR_WAIT,
    ST_CTL_REQ,
    ST_CTL_WAIT,
    ST_DAT_REQ,
    ST_DAT_WAIT,
    ST_SEND,
    ST_STAT_REQ
  } eng_state_e;

  typedef enum logic [1:0] {
    SEL_DESC_BASE = 2'd0,
    SEL_STAT_BASE = 2'd1,
    SEL_RING_CNT  = 2'd2,
    SEL_PROD      = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/txring_lane.sv
module txring_lane #(
  parameter int DW   = 32,
  parameter int SELW = $clog2(DW/8)
) (
  input  logic [DW-1:0]   word,
  input  logic [SELW-1:0] sel,
  output logic [7:0]      lane
);
  localparam int BPW = DW / 8;

  logic [7:0] bytes [BPW];

  for (genvar g = 0; g < BPW; g++) begin : g_split
    assign bytes[g] = word[8*g +: 8];
  end

  assign lane = bytes[sel];
endmodule

// File: rtl/txring_regs.sv
module txring_regs
  import txring_pkg::*;
#(
  parameter int AW   = 32,
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [1:0]      reg_sel,
  input  logic [AW-1:0]   reg_wdata,
  input  logic            adv,
  output logic [AW-1:0]   desc_base,
  output logic [AW-1:0]   stat_base,
  output logic [IDXW-1:0] cons,
  output logic            ring_avail
);
  logic [IDXW-1:0] cnt;
  logic [IDXW-1:0] prod;
  logic [IDXW-1:0] cons_step;

  assign cons_step  = (cons == cnt - 1'b1) ? '0 : cons + 1'b1;
  assign ring_avail = (prod != cons);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      desc_base <= '0;
      stat_base <= '0;
      cnt       <= '0;
      prod      <= '0;
      cons      <= '0;
    end else begin
      if (adv) cons <= cons_step;
      if (reg_we) begin
        case (reg_sel_e'(reg_sel))
          SEL_DESC_BASE: desc_base <= reg_wdata;
          SEL_STAT_BASE: stat_base <= reg_wdata;
          SEL_RING_CNT: begin
            cnt  <= reg_wdata[IDXW-1:0];
            prod <= '0;
            cons <= '0;
          end
          SEL_PROD: begin
            if (reg_wdata < AW'(cnt)) prod <= reg_wdata[IDXW-1:0];
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int IDXW    = 8,
  parameter int SIZEW   = 11,
  parameter int LASTBIT = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ring_avail,
  input  logic [AW-1:0]   desc_base,
  input  logic [AW-1:0]   stat_base,
  input  logic [IDXW-1:0] cons,
  output logic            adv,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            out_valid,
  output logic [7:0]      out_data,
  output logic            out_last,
  input  logic            out_ready
);
  localparam int BPW  = DW / 8;
  localparam int OFFW = $clog2(BPW);

  eng_state_e       st, st_nx;
  logic [AW-1:0]    cur_addr;
  logic [SIZEW-1:0] remain;
  logic [SIZEW-1:0] size_f;
  logic             last_f;
  logic [DW-1:0]    word_q;
  logic [AW-1:0]    desc_addr;
  logic [AW-1:0]    stat_addr;
  logic [DW-1:0]    stat_word;
  logic [OFFW-1:0]  off;
  logic [7:0]       lane_byte;
  logic             frag_end;
  logic             word_end;

  assign off       = cur_addr[OFFW-1:0];
  assign desc_addr = desc_base + AW'(cons) * AW'(2 * BPW);
  assign stat_addr = stat_base + AW'(cons) * AW'(BPW);
  assign frag_end  = (remain == '0);
  assign word_end  = (off == OFFW'(BPW - 1));

  always_comb begin
    stat_word              = '0;
    stat_word[DW-1]        = 1'b1;
    stat_word[LASTBIT]     = last_f;
    stat_word[SIZEW-1:0]   = size_f;
  end

  txring_lane #(.DW(DW), .SELW(OFFW)) u_lane (
    .word (word_q),
    .sel  (off),
    .lane (lane_byte)
  );

  always_comb begin
    st_nx     = st;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    adv       = 1'b0;
    case (st)
      ST_IDLE:     if (ring_avail) st_nx = ST_ADR_REQ;
      ST_ADR_REQ: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr;
        if (mem_gnt) st_nx = ST_ADR_WAIT;
      end
      ST_ADR_WAIT: if (mem_rvalid) st_nx = ST_CTL_REQ;
      ST_CTL_REQ: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + AW'(BPW);
        if (mem_gnt) st_nx = ST_CTL_WAIT;
      end
      ST_CTL_WAIT: if (mem_rvalid) st_nx = ST_DAT_REQ;
      ST_DAT_REQ: begin
        mem_req  = 1'b1;
        mem_addr = {cur_addr[AW-1:OFFW], {OFFW{1'b0}}};
        if (mem_gnt) st_nx = ST_DAT_WAIT;
      end
      ST_DAT_WAIT: if (mem_rvalid) st_nx = ST_SEND;
      ST_SEND: begin
        out_valid = 1'b1;
        out_data  = lane_byte;
        out_last  = last_f && frag_end;
        if (out_ready) begin
          if (frag_end)      st_nx = ST_STAT_REQ;
          else if (word_end) st_nx = ST_DAT_REQ;
        end
      end
      ST_STAT_REQ: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = stat_addr;
        mem_wdata = stat_word;
        if (mem_gnt) begin
          adv   = 1'b1;
          st_nx = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      size_f   <= '0;
      last_f   <= 1'b0;
      word_q   <= '0;
    end else begin
      st <= st_nx;
      case (st)
        ST_ADR_WAIT: if (mem_rvalid) cur_addr <= mem_rdata[AW-1:0];
        ST_CTL_WAIT: begin
          if (mem_rvalid) begin
            size_f <= mem_rdata[SIZEW-1:0];
            remain <= mem_rdata[SIZEW-1:0];
            last_f <= mem_rdata[LASTBIT];
          end
        end
        ST_DAT_WAIT: if (mem_rvalid) word_q <= mem_rdata;
        ST_SEND: begin
          if (out_ready) begin
            cur_addr <= cur_addr + 1'b1;
            if (!frag_end) remain <= remain - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txring_dma.sv
module txring_dma #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int IDXW    = 8,
  parameter int SIZEW   = 11,
  parameter int LASTBIT = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [1:0]      reg_sel,
  input  logic [AW-1:0]   reg_wdata,
  output logic [IDXW-1:0] cons_idx,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            out_valid,
  output logic [7:0]      out_data,
  output logic            out_last,
  input  logic            out_ready
);
  logic [AW-1:0] desc_base;
  logic [AW-1:0] stat_base;
  logic          ring_avail;
  logic          adv;

  txring_regs #(.AW(AW), .IDXW(IDXW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .adv        (adv),
    .desc_base  (desc_base),
    .stat_base  (stat_base),
    .cons       (cons_idx),
    .ring_avail (ring_avail)
  );

  txring_engine #(
    .AW(AW), .DW(DW), .IDXW(IDXW), .SIZEW(SIZEW), .LASTBIT(LASTBIT)
  ) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .ring_avail (ring_avail),
    .desc_base  (desc_base),
    .stat_base  (stat_base),
    .cons       (cons_idx),
    .adv        (adv),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_gnt    (mem_gnt),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last),
    .out_ready  (out_ready)
  );
endmodule

// File: rtl/txring_dma_chk.sv
module txring_dma_chk #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int IDXW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [1:0]      reg_sel,
  input logic [IDXW-1:0] cons_idx,
  input logic            mem_req,
  input logic            mem_we,
  input logic [AW-1:0]   mem_addr,
  input logic [DW-1:0]   mem_wdata,
  input logic            mem_gnt,
  input logic            out_valid,
  input logic [7:0]      out_data,
  input logic            out_last,
  input logic            out_ready
);
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10

  AST_CONS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_idx != $past(cons_idx)) |-> ($past(mem_req && mem_we && mem_gnt) || $past(reg_we && reg_sel == 2'd2))); // R7

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R5

  AST_NO_STREAM_DURING_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> !out_valid); // R6
endmodule

bind txring_dma txring_dma_chk #(.AW(AW), .DW(DW), .IDXW(IDXW)) u_chk (.*);

// File: tb/tb_txring_dma.sv
module tb_txring_dma;
  localparam int AW   = 32;
  localparam int DW   = 32;
  localparam int IDXW = 8;
  localparam logic [31:0] D_BASE = 32'h0000_1000;
  localparam logic [31:0] S_BASE = 32'h0000_3000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  logic [1:0]      reg_sel = '0;
  logic [AW-1:0]   reg_wdata = '0;
  logic [IDXW-1:0] cons_idx;
  logic            mem_req, mem_we;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata;
  logic            mem_gnt = 1'b0;
  logic            mem_rvalid = 1'b0;
  logic [DW-1:0]   mem_rdata = '0;
  logic            out_valid, out_last;
  logic [7:0]      out_data;
  logic            out_ready = 1'b0;

  txring_dma dut (.*);

  int unsigned vectors = 0, miscompares = 0;
  logic [31:0] mem [int unsigned];
  logic [7:0]  q_b[$];
  bit          q_l[$];
  logic [31:0] q_sa[$], q_sd[$];

  int m_cnt = 0, m_prod = 0, m_cons = 0, wslot = 0;
  bit run = 0;
  bit rd_pend = 0;
  int rd_lat = 0;
  logic [31:0] rd_addr = '0;
  int rd_since_stat = 0;
  int ready_pct = 100, gnt_pct = 100;
  bit h_pend = 0, h_sync = 0;
  logic [1:0]  h_sel = '0;
  logic [31:0] h_data = '0;
  bit collided = 0;
  bit prev_stall = 0, prev_wait = 0;
  logic [7:0]  prev_data = '0;
  logic        prev_last = 1'b0, prev_we = 1'b0;
  logic [31:0] prev_addr = '0;

  function automatic void chk(input bit ok, input string tag, input string what,
                              input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return mem.exists(a >> 2) ? mem[a >> 2] : 32'h0;
  endfunction

  function automatic void put_byte(input logic [31:0] a, input logic [7:0] v);
    logic [31:0] w;
    w = rd_word(a);
    w[8*a[1:0] +: 8] = v;
    mem[a >> 2] = w;
  endfunction

  always @(negedge clk) begin
    bit wgrant, rgrant;
    if (run) begin
      chk(cons_idx == IDXW'(m_cons), "R7", "consume index", 32'(cons_idx), m_cons);
      if (m_cons == m_prod)
        chk(!mem_req && !out_valid, "R2", "activity on empty ring", {mem_req, out_valid}, 0);
      if (prev_stall)
        chk(out_valid && out_data == prev_data && out_last == prev_last, "R9", "stalled byte moved",
            {out_valid, out_last, out_data}, {1'b1, prev_last, prev_data});
      if (prev_wait)
        chk(mem_req && mem_addr == prev_addr && mem_we == prev_we, "R10", "request changed before grant",
            mem_addr, prev_addr);
      if (out_valid) begin
        if (q_b.size() == 0) chk(1'b0, "R4", "unexpected byte", 32'(out_data), 0);
        else begin
          chk(out_data == q_b[0], "R4", "stream byte", 32'(out_data), 32'(q_b[0]));
          chk(out_last == q_l[0], "R5", "last flag", 32'(out_last), 32'(q_l[0]));
        end
      end
      mem_rvalid = 1'b0;
      if (rd_pend) begin
        rd_lat--;
        if (rd_lat == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rd_word(rd_addr);
          rd_pend    = 0;
        end
      end
      wgrant  = 0;
      rgrant  = 0;
      mem_gnt = mem_req && ($urandom_range(99) < gnt_pct);
      if (mem_gnt) begin
        if (mem_we) wgrant = 1; else rgrant = 1;
      end
      if (rgrant) begin
        if (rd_since_stat < 2)
          chk(mem_addr == D_BASE + 32'(8 * m_cons + 4 * rd_since_stat), "R3", "descriptor read address",
              mem_addr, D_BASE + 32'(8 * m_cons + 4 * rd_since_stat));
        rd_since_stat++;
        rd_pend = 1;
        rd_lat  = $urandom_range(1, 3);
        rd_addr = mem_addr;
      end
      if (wgrant) begin
        if (q_sa.size() == 0) chk(1'b0, "R6", "unexpected status write", mem_addr, 0);
        else begin
          chk(mem_addr == q_sa[0], "R6", "status address", mem_addr, q_sa[0]);
          chk(mem_wdata == q_sd[0], "R6", "status word", mem_wdata, q_sd[0]);
          void'(q_sa.pop_front());
          void'(q_sd.pop_front());
        end
        mem[mem_addr >> 2] = mem_wdata;
        m_cons = (m_cons == m_cnt - 1) ? 0 : m_cons + 1;
        rd_since_stat = 0;
      end
      out_ready = ($urandom_range(99) < ready_pct);
      if (out_valid && out_ready && q_b.size() != 0) begin
        void'(q_b.pop_front());
        void'(q_l.pop_front());
      end
      reg_we = 1'b0;
      if (h_pend && (!h_sync || wgrant)) begin
        reg_we    = 1'b1;
        reg_sel   = h_sel;
        reg_wdata = h_data;
        if (h_sel == 2'd2) begin
          m_cnt = int'(h_data[IDXW-1:0]); m_prod = 0; m_cons = 0;
        end else if (h_sel == 2'd3 && h_data < 32'(m_cnt)) m_prod = int'(h_data);
        if (h_sync) collided = 1;
        h_pend = 0;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_last  = out_last;
      prev_wait  = mem_req && !mem_gnt;
      prev_addr  = mem_addr;
      prev_we    = mem_we;
    end
  end

  task automatic host(input logic [1:0] sel, input logic [31:0] data, input bit sync);
    h_sel = sel; h_data = data; h_sync = sync; h_pend = 1;
    while (h_pend) @(negedge clk);
  endtask

  task automatic add_desc(input logic [31:0] ba, input int szm1, input bit lst);
    logic [31:0] da;
    logic [31:0] ctl;
    da  = D_BASE + 32'(8 * wslot);
    ctl = {1'b0, lst, 19'b0, 11'(szm1)};
    mem[da >> 2]       = ba;
    mem[(da >> 2) + 1] = ctl;
    for (int i = 0; i <= szm1; i++) begin
      logic [7:0] v;
      v = 8'($urandom);
      put_byte(ba + 32'(i), v);
      q_b.push_back(v);
      q_l.push_back(lst && i == szm1);
    end
    q_sa.push_back(S_BASE + 32'(4 * wslot));
    q_sd.push_back({1'b1, lst, 19'b0, 11'(szm1)});
    wslot = (wslot == m_cnt - 1) ? 0 : wslot + 1;
  endtask

  task automatic publish();
    host(2'd3, 32'(wslot), 0);
  endtask

  task automatic drain();
    while (m_cons != m_prod || q_b.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL R7 watchdog: consume index actual=%0d expected=%0d", cons_idx, m_prod);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cons_idx == '0 && !mem_req && !out_valid, "R1", "reset state",
        {cons_idx, mem_req, out_valid}, 0);
    run = 1;
    host(2'd0, D_BASE, 0);
    host(2'd1, S_BASE, 0);
    host(2'd2, 32'd4, 0);

    // single aligned fragment
    add_desc(32'h0000_8000, 7, 1);
    publish();
    drain();

    // three-fragment frame, odd alignments, throttled memory and consumer
    ready_pct = 60; gnt_pct = 50;
    add_desc(32'h0000_9001, 4, 0);
    add_desc(32'h0000_9103, 0, 0);
    add_desc(32'h0000_9206, 8, 1);
    publish();
    drain();

    // R8: out-of-range produce writes
    host(2'd3, 32'd9, 0);
    host(2'd3, 32'd4, 0);
    seen = 0;
    repeat (30) begin
      @(negedge clk);
      if (mem_req || out_valid) seen++;
    end
    chk(seen == 0, "R8", "cycles of activity after ignored produce write", seen, 0);
    chk(cons_idx == IDXW'(wslot), "R8", "consume index after ignored write", 32'(cons_idx), wslot);

    // R11: produce write in the cycle the status write is granted
    ready_pct = 100; gnt_pct = 100;
    add_desc(32'h0000_A000, 15, 1);
    publish();
    add_desc(32'h0000_A100, 5, 1);
    host(2'd3, 32'(wslot), 1);
    drain();
    chk(collided, "R11", "collision provoked", 32'(collided), 1);
    chk(cons_idx == IDXW'(wslot), "R11", "consume index after collision", 32'(cons_idx), wslot);

    // longest fragment
    ready_pct = 80; gnt_pct = 70;
    add_desc(32'h0000_C002, 2047, 1);
    publish();
    drain();

    // R12: count rewrite clears indices, then wrap a three-entry ring
    host(2'd2, 32'd3, 0);
    @(negedge clk);
    chk(cons_idx == '0, "R12", "consume index after count write", 32'(cons_idx), 0);
    wslot = 0;
    ready_pct = 70; gnt_pct = 60;
    for (int k = 0; k < 12; k++) begin
      add_desc(32'h0001_0000 + 32'(k * 256 + k % 4), $urandom_range(0, 20), (k % 3) == 2);
      if (k % 2 == 1) begin
        publish();
        drain();
      end
    end
    chk(q_sa.size() == 0, "R6", "status writes outstanding", q_sa.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule